// File: doc/BRIEF.md
# Converter Sample Buffer with Inverted Occupancy Flags

This block sits between an analog-to-digital converter and a host register bus. Every conversion-done strobe pushes one 16-bit result into a first-in first-out store of 1024 entries. The host drains results by reading the data port, and polls a status byte whose occupancy flags read 0 when their condition holds. The store is emptied by a three-step write pattern on an enable bit in the interrupt control register. There is no single flush strobe.

Two interrupt request lines are latched on the rising edge of a selectable condition. The data line watches either the conversion strobe or the half-full level. The auxiliary line watches either a timer tick or an external trigger. Both lines stay high until the host writes to the clear offset.

Top module: `sample_fifo_ctrl`

## Requirements
- R1: A read of offset 0x00 returns the oldest stored sample and removes it. A read while the store is empty returns an undefined value and leaves the store unchanged. Samples leave in the order they arrived.
- R2: Status byte (offset 0x08) bit 4 reads 0 when the store holds no samples, and 1 otherwise.
- R3: Status bit 5 reads 0 when the store holds 512 or more samples (DEPTH/2), and 1 otherwise.
- R4: Status bit 6 reads 0 when the store holds 1024 samples. Bit 7 mirrors the converter busy input (1 = busy). Bits 2:0 show the range code input. Bit 3 reads 0.
- R5: A conversion strobe arriving while the store is full is dropped. The only exception is a same-cycle read of offset 0x00; then the sample is accepted and the store stays full.
- R6: Offset 0x0C holds four control bits and reads them back in bits 3:0. Bit 0 selects the data-line source, bit 1 selects the auxiliary-line source, bit 2 is the store enable bit, and bit 3 is spare.
- R7: A write that clears bit 2 while it is 1 empties the store. Since the bit resets to 0, this is the 0→1→0 pattern. Writing bit 2 as 1 alone does not empty the store. A flush wins over a conversion strobe in the same cycle.
- R8: With control bit 0 = 0, the data line latches on a rising conversion strobe. With control bit 0 = 1, it latches on the rising half-full condition, which is visible one cycle after the level reaches 512.
- R9: With control bit 1 = 0, the auxiliary line latches on a rising timer tick. With control bit 1 = 1, it latches on a rising external trigger. The unselected input has no effect.
- R10: Any write to offset 0x48 drops both latched lines. If a line's selected condition rises in the same cycle, that line stays set.
- R11: After reset, the store is empty, the control bits are 0 and both request lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at offset 0x00) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed offset (combinational) |
| conv_done | input | 1 | Conversion finished strobe, pushes conv_data |
| conv_data | input | 16 | Converter result |
| conv_busy | input | 1 | Converter busy level |
| range_code | input | 3 | Current input range code |
| tick_evt | input | 1 | Timer tick |
| ext_evt | input | 1 | External trigger |
| irq_data | output | 1 | Latched data-line request |
| irq_aux | output | 1 | Latched auxiliary-line request |

## Verification
Three collisions are provoked directly, each with a known expected result.

- A conversion strobe is driven in the same cycle as a request-clear write. The bench expects the data line to stay set.
- A conversion strobe is driven in the same cycle as a flush write. The bench expects the store to read empty afterwards.
- A strobe and a data-port read are driven together while the store is full. The bench expects the occupancy to stay at full, and the sample order to hold when the store is later drained.

Long random runs mix all three collisions, and each cycle is judged against a queue model kept in the bench.

// File: rtl/sfc_pkg.sv
// Shared offsets, status bit positions and control register layout for the
// sample FIFO controller. Assumes a byte-addressed register bus.
package sfc_pkg;

    localparam logic [7:0] OFS_DATA = 8'h00;
    localparam logic [7:0] OFS_STAT = 8'h08;
    localparam logic [7:0] OFS_ICTL = 8'h0C;
    localparam logic [7:0] OFS_ICLR = 8'h48;

    localparam int ST_BUSY    = 7;
    localparam int ST_FULL_N  = 6;
    localparam int ST_HALF_N  = 5;
    localparam int ST_EMPTY_N = 4;

    // Control bits, MSB first: spare, store enable, aux select, data select
    typedef struct packed {
        logic spare;
        logic fen;
        logic sel_aux;
        logic sel_data;
    } ictl_t;

endpackage

// File: rtl/sfc_store.sv
// Circular sample store with occupancy counter.
// Assumes push and pop are single-cycle requests. A flush overrides both.
// A push while full is accepted only together with a pop.
module sfc_store #(
    parameter int W     = 16,
    parameter int DEPTH = 1024
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push_req,
    input  logic                         pop_req,
    input  logic [W-1:0]                 wdata,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty,
    output logic                         half
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH-1);
    localparam logic [CW-1:0] HALF = CW'(DEPTH/2);
    localparam logic [CW-1:0] FULLV = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_pop, do_push;

    assign full  = (level == FULLV);
    assign empty = (level == '0);
    assign half  = (level >= HALF);
    assign rdata = mem[rd_ptr];

    // Qualify requests against occupancy and flush
    always_comb begin
        do_pop  = pop_req && !empty && !flush;
        do_push = push_req && (!full || do_pop) && !flush;
    end

    // Sample storage, written on accepted pushes only
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/sfc_ctrl_reg.sv
// Interrupt control register with flush detection and request-clear decode.
// Assumes a write is a single-cycle strobe. The flush is a falling store
// enable bit, which after reset implies the 0->1->0 pattern.
module sfc_ctrl_reg
    import sfc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [7:0]  addr,
    input  logic [3:0]  wdata,
    output ictl_t       ctl,
    output logic        flush,
    output logic        req_clr
);
    logic ctl_wr;

    // Decode writes aimed at this block's control offsets
    always_comb begin
        ctl_wr  = wr && (addr == OFS_ICTL);
        flush   = ctl_wr && ctl.fen && !wdata[2];
        req_clr = wr && (addr == OFS_ICLR);
    end

    // Hold the control bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl <= '0;
        else if (ctl_wr) ctl <= ictl_t'(wdata);
    end
endmodule

// File: rtl/sfc_irq_latch.sv
// One interrupt request line: picks one of two conditions, latches on its
// rising edge and holds until cleared. A new edge beats a same-cycle clear.
module sfc_irq_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic cond_a,
    input  logic cond_b,
    input  logic clr,
    output logic req
);
    logic cond, cond_q;

    // Select the active condition
    always_comb cond = sel ? cond_b : cond_a;

    // Edge detect and latch the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            cond_q <= cond;
            if (cond && !cond_q) req <= 1'b1;
            else if (clr)        req <= 1'b0;
        end
    end
endmodule

// File: rtl/sample_fifo_ctrl.sv
// Top of the sample buffer: store, control register, two request lines and
// the read mux. The occupancy flags read 0 when their condition holds.
module sample_fifo_ctrl
    import sfc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_busy,
    input  logic [2:0]        range_code,
    input  logic              tick_evt,
    input  logic              ext_evt,
    output logic              irq_data,
    output logic              irq_aux
);
    localparam int CW    = $clog2(DEPTH+1);
    localparam int NLINE = 2;

    ictl_t             ctl_q;
    logic              flush, req_clr, pop_req;
    logic              full, empty, half;
    logic [CW-1:0]     level;
    logic [DATA_W-1:0] head;
    logic [7:0]        status;
    logic [NLINE-1:0]  line_sel, line_a, line_b, line_req;

    assign pop_req = bus_rd && (bus_addr == OFS_DATA);

    sfc_ctrl_reg i_ctl (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata[3:0]), .ctl(ctl_q), .flush(flush), .req_clr(req_clr)
    );

    sfc_store #(.W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push_req(conv_done),
        .pop_req(pop_req), .wdata(conv_data), .rdata(head), .level(level),
        .full(full), .empty(empty), .half(half)
    );

    // Route the condition pairs to the request lines
    always_comb begin
        line_sel = {ctl_q.sel_aux, ctl_q.sel_data};
        line_a   = {tick_evt, conv_done};
        line_b   = {ext_evt, half};
    end

    for (genvar g = 0; g < NLINE; g++) begin : g_line
        sfc_irq_latch i_line (
            .clk(clk), .rst_n(rst_n), .sel(line_sel[g]), .cond_a(line_a[g]),
            .cond_b(line_b[g]), .clr(req_clr), .req(line_req[g])
        );
    end

    assign irq_data = line_req[0];
    assign irq_aux  = line_req[1];

    // Assemble the status byte with inverted occupancy flags
    always_comb begin
        status             = {5'b0, range_code};
        status[ST_BUSY]    = conv_busy;
        status[ST_FULL_N]  = !full;
        status[ST_HALF_N]  = !half;
        status[ST_EMPTY_N] = !empty;
    end

    // Read mux by offset
    always_comb begin
        case (bus_addr)
            OFS_DATA: bus_rdata = head;
            OFS_STAT: bus_rdata = DATA_W'(status);
            OFS_ICTL: bus_rdata = DATA_W'(ctl_q);
            default:  bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sfc_checker.sv
// Temporal checks on the sample buffer, bound into the top module.
module sfc_checker #(
    parameter int DEPTH = 1024
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_wr,
    input logic                       bus_rd,
    input logic [7:0]                 bus_addr,
    input logic [15:0]                bus_wdata,
    input logic                       conv_done,
    input logic                       tick_evt,
    input logic                       ext_evt,
    input logic                       irq_data,
    input logic                       irq_aux,
    input logic [3:0]                 ctl_q,
    input logic [$clog2(DEPTH+1)-1:0] level
);
    logic rd_pop, flush_wr, clr_wr;
    assign rd_pop   = bus_rd && bus_addr == 8'h00;
    assign flush_wr = bus_wr && bus_addr == 8'h0C && ctl_q[2] && !bus_wdata[2];
    assign clr_wr   = bus_wr && bus_addr == 8'h48;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= ($clog2(DEPTH+1))'(DEPTH)); // R5
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (level == ($clog2(DEPTH+1))'(DEPTH) && !rd_pop && !flush_wr) |=>
        level == ($clog2(DEPTH+1))'(DEPTH)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> level == '0); // R7
    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && !conv_done) |=> level == '0); // R1
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_data && !clr_wr) |=> irq_data); // R10
    AST_AUX_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !tick_evt && !ext_evt) |=> !irq_aux); // R10
endmodule

bind sample_fifo_ctrl sfc_checker #(.DEPTH(DEPTH)) i_sfc_checker (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .conv_done(conv_done),
    .tick_evt(tick_evt), .ext_evt(ext_evt), .irq_data(irq_data),
    .irq_aux(irq_aux), .ctl_q(ctl_q), .level(level)
);

// File: tb/test_sample_fifo_ctrl.sv
module test_sample_fifo_ctrl;
    localparam int DEPTH = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = '0, bus_rdata, conv_data = '0;
    logic        conv_done = 1'b0, conv_busy = 1'b0, tick_evt = 1'b0, ext_evt = 1'b0;
    logic [2:0]  range_code = 3'd5;
    logic        irq_data, irq_aux;

    int checks = 0, errors = 0;
    bit finished = 0;

    logic [15:0] q[$];
    logic [3:0]  m_ctl = '0;
    logic [1:0]  m_req = '0, m_prev = '0;

    always #5 clk = ~clk;

    sample_fifo_ctrl i_sample_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_done(conv_done), .conv_data(conv_data), .conv_busy(conv_busy),
        .range_code(range_code), .tick_evt(tick_evt), .ext_evt(ext_evt),
        .irq_data(irq_data), .irq_aux(irq_aux)
    );

    function automatic logic [7:0] exp_status(int n, logic busy, logic [2:0] rc);
        exp_status = {busy, n != DEPTH, n < DEPTH/2, n != 0, 1'b0, rc};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_status(string req);
        bus_wr = 0; bus_rd = 0; bus_addr = 8'h08; conv_done = 0; tick_evt = 0; ext_evt = 0;
        #1 check(req, 32'(bus_rdata), 32'(exp_status(q.size(), conv_busy, range_code)));
    endtask

    // One bus cycle: drive, check read data, clock, update model, check requests
    task automatic cyc(input logic wr, input logic rd, input logic [7:0] a,
                       input logic [15:0] wd, input logic cd, input logic [15:0] cdat,
                       input logic tk, input logic ex);
        bit fl, pop, push;
        logic [1:0] cond;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        conv_done = cd; conv_data = cdat; tick_evt = tk; ext_evt = ex;
        #1;
        if (rd && a == 8'h00 && q.size() > 0) check("R1 data order", 32'(bus_rdata), 32'(q[0]));
        @(posedge clk);
        fl   = wr && a == 8'h0C && m_ctl[2] && !wd[2];
        pop  = rd && a == 8'h00 && q.size() > 0 && !fl;
        push = cd && (q.size() < DEPTH || pop) && !fl;
        cond[0] = m_ctl[0] ? (q.size() >= DEPTH/2) : cd;
        cond[1] = m_ctl[1] ? ex : tk;
        for (int i = 0; i < 2; i++) begin
            if (cond[i] && !m_prev[i]) m_req[i] = 1'b1;
            else if (wr && a == 8'h48) m_req[i] = 1'b0;
        end
        m_prev = cond;
        if (fl) q.delete();
        if (pop) void'(q.pop_front());
        if (push) q.push_back(cdat);
        if (wr && a == 8'h0C) m_ctl = wd[3:0];
        @(negedge clk);
        check("R8 data line", 32'(irq_data), 32'(m_req[0]));
        check("R9 aux line", 32'(irq_aux), 32'(m_req[1]));
    endtask

    task automatic idle();
        cyc(0, 0, 8'h08, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: reset state
        chk_status("R11 reset status");
        check("R11 data line low", 32'(irq_data), 0);
        check("R11 aux line low", 32'(irq_aux), 0);
        bus_addr = 8'h0C; #1 check("R6 ctl reset", 32'(bus_rdata), 0);

        // R8 strobe source, R10 clear, then set beats clear
        cyc(0, 0, 8'h08, 0, 1, 16'hA001, 0, 0);
        chk_status("R2 not empty");
        check("R8 strobe latch", 32'(irq_data), 1);
        cyc(1, 0, 8'h48, 16'h1234, 0, 0, 0, 0);
        check("R10 clear", 32'(irq_data), 0);
        cyc(1, 0, 8'h48, 0, 1, 16'hA002, 0, 0);
        check("R10 set beats clear", 32'(irq_data), 1);
        cyc(1, 0, 8'h48, 0, 0, 0, 0, 0);

        // R6 half-full source; fill past full
        cyc(1, 0, 8'h0C, 16'h0001, 0, 0, 0, 0);
        bus_addr = 8'h0C; #1 check("R6 ctl readback", 32'(bus_rdata), 1);
        while (q.size() < DEPTH/2 - 1) cyc(0, 0, 8'h08, 0, 1, 16'($urandom), 0, 0);
        chk_status("R3 below half");
        cyc(0, 0, 8'h08, 0, 1, 16'hB000, 0, 0);
        chk_status("R3 at half");
        check("R8 half not yet", 32'(irq_data), 0);
        idle();
        check("R8 half latched", 32'(irq_data), 1);
        while (q.size() < DEPTH) cyc(0, 0, 8'h08, 0, 1, 16'($urandom), 0, 0);
        chk_status("R4 full status");
        for (int i = 0; i < 4; i++) cyc(0, 0, 8'h08, 0, 1, 16'hDEAD, 0, 0);
        chk_status("R5 drop while full");
        cyc(0, 1, 8'h00, 0, 1, 16'hC0DE, 0, 0);
        chk_status("R5 push with pop stays full");

        // R7 flush sequence
        cyc(1, 0, 8'h0C, 16'h0005, 0, 0, 0, 0);
        chk_status("R7 enable alone keeps data");
        cyc(1, 0, 8'h0C, 16'h0001, 1, 16'h5555, 0, 0);
        chk_status("R7 flush empties");

        // R9 auxiliary sources
        cyc(1, 0, 8'h0C, 16'h0000, 0, 0, 0, 0);
        cyc(0, 0, 8'h08, 0, 0, 0, 0, 1);
        check("R9 ext ignored", 32'(irq_aux), 0);
        cyc(0, 0, 8'h08, 0, 0, 0, 1, 0);
        check("R9 tick latch", 32'(irq_aux), 1);
        cyc(1, 0, 8'h48, 0, 0, 0, 0, 0);
        cyc(1, 0, 8'h0C, 16'h0002, 0, 0, 0, 0);
        cyc(0, 0, 8'h08, 0, 0, 0, 1, 0);
        check("R9 tick ignored", 32'(irq_aux), 0);
        cyc(0, 0, 8'h08, 0, 0, 0, 0, 1);
        check("R9 ext latch", 32'(irq_aux), 1);

        // R4 busy and range fields
        conv_busy = 1; range_code = 3'd2;
        chk_status("R4 busy and range");
        conv_busy = 0;

        // Random mix
        for (int i = 0; i < 6000; i++) begin
            int r = int'($urandom % 64);
            logic wr = 0; logic [7:0] a = 8'h00; logic [15:0] wd = '0;
            if (r == 0) begin wr = 1; a = 8'h0C; wd = 16'($urandom % 16); end
            else if (r < 5) begin wr = 1; a = 8'h48; end
            cyc(wr, !wr && ($urandom % 10 < 3), a, wd, $urandom % 10 < 6,
                16'($urandom), $urandom % 8 == 0, $urandom % 8 == 0);
            if (i % 250 == 0) chk_status("R2 random status");
        end
        // Drain, then read on empty
        while (q.size() > 0) cyc(0, 1, 8'h00, 0, 0, 0, 0, 0);
        cyc(0, 1, 8'h00, 0, 0, 0, 0, 0);
        chk_status("R1 read on empty");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule